// File: doc/BRIEF.md
# Chip-Select and Wait-State Controller

This block sits between a CPU's 24-bit logical address and the external memory bus. Four programmable windows each claim part of the logical space and drive one active-low chip select. Each window also sets a data-bus width, a number of wait states and a bank value. That bank value supplies the upper bits of a 26-bit physical address. Any access that no enabled window claims falls into a default area. The default area has its own width and wait setting and drives no chip select.

Software programs the windows through a byte-wide write port. A window's programmed size is the logical size that suits the local map, not the size of the memory behind it. The bank value picks which part of a larger memory the window reaches. For 16-bit memories the external address is the physical byte address shifted right by one. While the programmed wait cycles run, the controller holds the CPU's ready line low and keeps the chip select asserted.

Top module: `csWaitCtrl`

## Requirements
- R1: After reset, all chip selects are high and cpuReady is high. Windows 0, 1 and 3 are disabled. Window 2 is enabled with start 80H, mask all ones, a 16-bit bus, 2 waits and bank 0, so it claims 800000H to FFFFFFH. The default area uses a 16-bit bus with 2 waits.
- R2: Configuration writes use cfgAddr[4:2] for the area (0 to 3 select a window, 4 selects the default area) and cfgAddr[1:0] for the field (0 start, 1 mask, 2 control, 3 bank from cfgData[3:0]). An enabled window w claims an access when accAddr[23:16] equals its start byte on every bit that the mask does not ignore. Mask bit m makes address bit m+L don't-care, with L = 13, 14, 15, 15 for windows 0 to 3. Mask bits that land below address bit 16 have no effect.
- R3: When several enabled windows claim an address, the lowest-numbered one wins. At most one csN bit is ever low.
- R4: An access that no enabled window claims drives no chip select low. It takes its width and waits from the default area's control byte, and bit 7 of that byte is ignored.
- R5: In a control byte, bit 7 enables the window and bit 3 = 1 selects an 8-bit bus (byteBus = 1). Bits [2:0] code the waits: 011 gives 0, 001 gives 1, 000 gives 2, 101 gives 3, and every other code gives 2.
- R6: accStart is sampled at a rising edge while the block is idle. From the next cycle, csN, extAddr and byteBus hold the access's values for W+1 cycles, where W is the access's wait count. cpuReady is low for the first W of those cycles. After that, csN returns to all ones.
- R7: For a window access, the physical address is {bank[3:0], accAddr[21:0]}. For a default-area access, it is {2'b00, accAddr}.
- R8: extAddr is the physical address shifted right by one for a 16-bit bus, and the physical address unchanged for an 8-bit bus.
- R9: An accStart that arrives during an access is ignored. The outputs hold their values, and the access ends on its original schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Area in [4:2], field in [1:0] |
| cfgData | input | 8 | Configuration write data |
| accStart | input | 1 | Starts a bus access |
| accAddr | input | 24 | Logical byte address of the access |
| csN | output | 4 | Active-low chip selects, one per window |
| extAddr | output | 26 | External address after bank and width shift |
| byteBus | output | 1 | 1 for an 8-bit bus, 0 for a 16-bit bus |
| cpuReady | output | 1 | Low while wait cycles are being inserted |

## Verification
The bench aims at overlapping windows, where a priority fault would select a higher-numbered window or more than one. It also aims at addresses just outside a window's edge, where a mask mapped to the wrong bits would claim or miss them. Disabled windows and odd wait codes are covered; a decoding fault there would stretch the access by the wrong number of cycles or pick the wrong bus width. A start pulse during a busy access is covered too; a design that accepted it would change extAddr or chip select mid-access. Every access is checked cycle by cycle, so a release off by one cycle shows up as a chip select held too long or dropped early.

// File: rtl/cswPkg.sv
package cswPkg;
  localparam int ADDR_W    = 24;
  localparam int NUM_WIN   = 4;
  localparam int BANK_W    = 4;
  localparam int OFS_W     = 22;
  localparam int PHYS_W    = OFS_W + BANK_W;
  localparam int START_LO  = ADDR_W - 8;
  localparam int WAIT_W    = 2;
  localparam int AREA_W    = $clog2(NUM_WIN + 1);
  localparam int CFG_AW    = AREA_W + 2;
  localparam int BOOT_WIN  = 2;

  localparam logic [1:0] FLD_START = 2'd0;
  localparam logic [1:0] FLD_MASK  = 2'd1;
  localparam logic [1:0] FLD_CTRL  = 2'd2;

  localparam logic [7:0] BOOT_START = 8'h80;

  typedef struct packed {
    logic grab;   // capture the decoded access
    logic drop;   // end the access
  } cswStrobe_t;

  typedef struct packed {
    logic              enable;
    logic              byteBus;
    logic [WAIT_W-1:0] waits;
  } cswMode_t;

  localparam cswMode_t MODE_OFF  = '{enable: 1'b0, byteBus: 1'b0, waits: '0};
  localparam cswMode_t BOOT_MODE = '{enable: 1'b1, byteBus: 1'b0, waits: WAIT_W'(2)};

  // Lowest address bit that mask bit 0 reaches, per window.
  function automatic int maskLo(input int win);
    case (win)
      0:       return 13;
      1:       return 14;
      default: return 15;
    endcase
  endfunction

  function automatic cswMode_t decodeCtrl(input logic [7:0] c);
    cswMode_t m;
    m.enable  = c[7];
    m.byteBus = c[3];
    case (c[2:0])
      3'b011:  m.waits = WAIT_W'(0);
      3'b001:  m.waits = WAIT_W'(1);
      3'b101:  m.waits = WAIT_W'(3);
      default: m.waits = WAIT_W'(2);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cswWinMatch.sv
module cswWinMatch #(
  parameter int KEEP = 5
) (
  input  logic [7:0]      addrHi,
  input  logic [7:0]      start,
  input  logic [KEEP-1:0] maskKeep,
  input  logic            enable,
  output logic            hit
);
  // Stored mask bit b already lines up with address bit 16+b.
  logic [7:0] ignore;
  assign ignore = 8'(maskKeep);
  assign hit    = enable && (((addrHi ^ start) & ~ignore) == 8'h00);
endmodule

// File: rtl/cswDatapath.sv
module cswDatapath
  import cswPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CFG_AW-1:0]   cfgAddr,
  input  logic [7:0]          cfgData,
  input  logic [ADDR_W-1:0]   accAddr,
  input  cswStrobe_t          strobe,
  output logic [WAIT_W-1:0]   waitsNext,
  output logic [NUM_WIN-1:0]  csN,
  output logic [PHYS_W-1:0]   extAddr,
  output logic                byteBus
);
  logic [AREA_W-1:0] cfgArea;
  logic [1:0]        cfgField;
  assign cfgArea  = cfgAddr[CFG_AW-1:2];
  assign cfgField = cfgAddr[1:0];

  logic [NUM_WIN-1:0]             hitVec;
  cswMode_t [NUM_WIN-1:0]         modeVec;
  logic [NUM_WIN-1:0][BANK_W-1:0] bankVec;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam int KEEP = 8 - (START_LO - maskLo(w));
      localparam bit BOOT = (w == BOOT_WIN);
      logic [7:0]        startQ;
      logic [KEEP-1:0]   maskQ;
      cswMode_t          modeQ;
      logic [BANK_W-1:0] bankQ;
      logic              wrSel;

      assign wrSel = cfgWe && (cfgArea == AREA_W'(w));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          startQ <= BOOT ? BOOT_START : 8'h00;
          maskQ  <= {KEEP{BOOT}};
          modeQ  <= BOOT ? BOOT_MODE : MODE_OFF;
          bankQ  <= '0;
        end else if (wrSel) begin
          case (cfgField)
            FLD_START: startQ <= cfgData;
            FLD_MASK:  maskQ  <= cfgData[7 -: KEEP];
            FLD_CTRL:  modeQ  <= decodeCtrl(cfgData);
            default:   bankQ  <= cfgData[BANK_W-1:0];
          endcase
        end
      end

      assign modeVec[w] = modeQ;
      assign bankVec[w] = bankQ;

      cswWinMatch #(.KEEP(KEEP)) u_match (
        .addrHi  (accAddr[ADDR_W-1 -: 8]),
        .start   (startQ),
        .maskKeep(maskQ),
        .enable  (modeQ.enable),
        .hit     (hitVec[w])
      );
    end
  endgenerate

  // Default area keeps only width and waits.
  logic              csxByteQ;
  logic [WAIT_W-1:0] csxWaitsQ;
  cswMode_t          csxDec;
  assign csxDec = decodeCtrl(cfgData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csxByteQ  <= 1'b0;
      csxWaitsQ <= WAIT_W'(2);
    end else if (cfgWe && cfgArea == AREA_W'(NUM_WIN) && cfgField == FLD_CTRL) begin
      csxByteQ  <= csxDec.byteBus;
      csxWaitsQ <= csxDec.waits;
    end
  end

  // Lowest-numbered claiming window wins.
  logic [NUM_WIN-1:0] pickVec;
  logic               pickHit;
  logic               pickByte;
  logic [BANK_W-1:0]  pickBank;
  logic [WAIT_W-1:0]  pickWaits;

  always_comb begin
    pickVec   = '0;
    pickHit   = 1'b0;
    pickByte  = csxByteQ;
    pickWaits = csxWaitsQ;
    pickBank  = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hitVec[w]) begin
        pickVec    = '0;
        pickVec[w] = 1'b1;
        pickHit    = 1'b1;
        pickByte   = modeVec[w].byteBus;
        pickWaits  = modeVec[w].waits;
        pickBank   = bankVec[w];
      end
    end
  end

  logic [PHYS_W-1:0] physAddr;
  logic [PHYS_W-1:0] extNext;
  assign physAddr  = pickHit ? {pickBank, accAddr[OFS_W-1:0]} : PHYS_W'(accAddr);
  assign extNext   = pickByte ? physAddr : (physAddr >> 1);
  assign waitsNext = pickWaits;

  logic [NUM_WIN-1:0] selQ;
  logic [PHYS_W-1:0]  extQ;
  logic               byteQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      extQ  <= '0;
      byteQ <= 1'b0;
    end else if (strobe.grab) begin
      selQ  <= pickVec;
      extQ  <= extNext;
      byteQ <= pickByte;
    end else if (strobe.drop) begin
      selQ  <= '0;
    end
  end

  assign csN     = ~selQ;
  assign extAddr = extQ;
  assign byteBus = byteQ;

  // R3: never more than one chip select low
  a_r3_single_cs: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R4: an unclaimed access selects nothing
  a_r4_csx_no_select: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.grab && hitVec == '0) |=> (&csN));

  // R9: a running window access keeps its outputs
  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!(&csN) && !strobe.drop) |=> ($stable(extAddr) && $stable(csN) && $stable(byteBus)));
endmodule

// File: rtl/cswControl.sv
module cswControl
  import cswPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accStart,
  input  logic [WAIT_W-1:0] waitsNext,
  output cswStrobe_t        strobe,
  output logic              cpuReady
);
  logic              activeQ;
  logic [WAIT_W-1:0] cntQ;

  assign strobe.grab = accStart && !activeQ;
  assign strobe.drop = activeQ && (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      cntQ    <= '0;
    end else if (strobe.grab) begin
      activeQ <= 1'b1;
      cntQ    <= waitsNext;
    end else if (strobe.drop) begin
      activeQ <= 1'b0;
    end else if (activeQ) begin
      cntQ    <= cntQ - 1'b1;
    end
  end

  assign cpuReady = !(activeQ && cntQ != '0);

  // R6: ready only drops right after an access is captured
  a_r6_ready_falls_on_grab: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuReady) |-> $past(strobe.grab));
endmodule

// File: rtl/csWaitCtrl.sv
module csWaitCtrl
  import cswPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CFG_AW-1:0]   cfgAddr,
  input  logic [7:0]          cfgData,
  input  logic                accStart,
  input  logic [ADDR_W-1:0]   accAddr,
  output logic [NUM_WIN-1:0]  csN,
  output logic [PHYS_W-1:0]   extAddr,
  output logic                byteBus,
  output logic                cpuReady
);
  cswStrobe_t        strobe;
  logic [WAIT_W-1:0] waitsNext;

  cswControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accStart (accStart),
    .waitsNext(waitsNext),
    .strobe   (strobe),
    .cpuReady (cpuReady)
  );

  cswDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .accAddr  (accAddr),
    .strobe   (strobe),
    .waitsNext(waitsNext),
    .csN      (csN),
    .extAddr  (extAddr),
    .byteBus  (byteBus)
  );
endmodule

// File: tb/tb_csWaitCtrl.sv
module tb_csWaitCtrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgAddr = '0;
  logic [7:0]  cfgData = '0;
  logic        accStart = 1'b0;
  logic [23:0] accAddr = '0;
  logic [3:0]  csN;
  logic [25:0] extAddr;
  logic        byteBus;
  logic        cpuReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] bStart [4];
  logic [7:0] bMask  [4];
  logic [7:0] bCtrl  [4];
  logic [7:0] bBank  [4];
  logic [7:0] bCsx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  csWaitCtrl dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .accStart(accStart), .accAddr(accAddr), .csN(csN), .extAddr(extAddr),
    .byteBus(byteBus), .cpuReady(cpuReady)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int waitOf(input logic [7:0] c);
    case (c[2:0])
      3'b011:  return 0;
      3'b001:  return 1;
      3'b101:  return 3;
      default: return 2;
    endcase
  endfunction

  function automatic int loOf(input int w);
    if (w == 0) return 13;
    if (w == 1) return 14;
    return 15;
  endfunction

  function automatic bit matchW(input int w, input logic [23:0] a);
    if (!bCtrl[w][7]) return 1'b0;
    for (int b = 0; b < 8; b++) begin
      int m;
      bit ign;
      m = 16 + b - loOf(w);
      ign = (m <= 7) ? bMask[w][m] : 1'b0;
      if (!ign && a[16 + b] != bStart[w][b]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic model(input logic [23:0] a, output int win, output int waits,
                       output bit b8, output logic [25:0] ext);
    logic [25:0] phys;
    win = 4;
    for (int w = 3; w >= 0; w--) if (matchW(w, a)) win = w;
    if (win < 4) begin
      b8 = bCtrl[win][3];
      waits = waitOf(bCtrl[win]);
      phys = {bBank[win][3:0], a[21:0]};
    end else begin
      b8 = bCsx[3];
      waits = waitOf(bCsx);
      phys = {2'b00, a};
    end
    ext = b8 ? phys : (phys >> 1);
  endtask

  task automatic cfgWrite(input int area, input int field, input logic [7:0] d);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgAddr = {3'(area), 2'(field)};
    cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (area < 4) begin
      case (field)
        0: bStart[area] = d;
        1: bMask[area] = d;
        2: bCtrl[area] = d;
        default: bBank[area] = d;
      endcase
    end else if (area == 4 && field == 2) begin
      bCsx = d;
    end
  endtask

  task automatic doAccess(input logic [23:0] a, input bit poke);
    int win, waits;
    bit b8;
    logic [25:0] ext;
    logic [3:0] expCs;
    model(a, win, waits, b8, ext);
    expCs = (win < 4) ? ~(4'b1 << win) : 4'hF;
    @(negedge clk);
    accStart = 1'b1;
    accAddr = a;
    @(negedge clk);
    accStart = 1'b0;
    for (int k = 0; k <= waits; k++) begin
      if (poke && k == 0 && waits > 0) begin
        accStart = 1'b1;
        accAddr = ~a;
      end else begin
        accStart = 1'b0;
      end
      chk(poke ? "R9 R3" : "R2 R3 R4", "csN", 32'(csN), 32'(expCs));
      chk(poke ? "R9 R7 R8" : "R7 R8", "extAddr", 32'(extAddr), 32'(ext));
      chk("R5", "byteBus", 32'(byteBus), 32'(b8));
      chk("R6", "cpuReady", 32'(cpuReady), 32'(k == waits));
      @(negedge clk);
    end
    accStart = 1'b0;
    chk(poke ? "R9" : "R6", "csN released", 32'(csN), 32'hF);
    chk("R6", "cpuReady idle", 32'(cpuReady), 32'h1);
  endtask

  initial begin
    for (int w = 0; w < 4; w++) begin
      bStart[w] = 8'h00; bMask[w] = 8'h00; bCtrl[w] = 8'h00; bBank[w] = 8'h00;
    end
    bStart[2] = 8'h80; bMask[2] = 8'hFF; bCtrl[2] = 8'h80;
    bCsx = 8'h00;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    chk("R1", "csN in reset", 32'(csN), 32'hF);
    chk("R1", "cpuReady in reset", 32'(cpuReady), 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "csN after reset", 32'(csN), 32'hF);

    // R1: boot window and default area straight after reset
    doAccess(24'hFFFFFE, 1'b0);
    doAccess(24'h800000, 1'b0);
    doAccess(24'h7FFFFF, 1'b0);

    // R2 R5 R7 R8: a typical four-window map
    cfgWrite(0, 0, 8'h00); cfgWrite(0, 1, 8'hFF); cfgWrite(0, 2, 8'h89); cfgWrite(0, 3, 8'h00);
    cfgWrite(1, 0, 8'h40); cfgWrite(1, 1, 8'hFF); cfgWrite(1, 2, 8'h80); cfgWrite(1, 3, 8'h02);
    cfgWrite(2, 0, 8'hC0); cfgWrite(2, 1, 8'h7F); cfgWrite(2, 2, 8'hC3); cfgWrite(2, 3, 8'h01);
    cfgWrite(3, 0, 8'h80); cfgWrite(3, 1, 8'h7F); cfgWrite(3, 2, 8'h85); cfgWrite(3, 3, 8'h0D);
    doAccess(24'h123457, 1'b0);
    doAccess(24'h1FFFFF, 1'b0);
    doAccess(24'h200000, 1'b0);
    doAccess(24'h654321, 1'b0);
    doAccess(24'hE00001, 1'b0);
    doAccess(24'h9ABCDE, 1'b0);

    // R3: overlap, window 0 beats window 1
    cfgWrite(1, 0, 8'h00);
    doAccess(24'h100000, 1'b0);
    doAccess(24'h300000, 1'b0);
    // R5: disabled window and odd wait code
    cfgWrite(0, 2, 8'h05);
    doAccess(24'h100000, 1'b0);
    cfgWrite(1, 2, 8'h86);
    doAccess(24'h100000, 1'b0);
    // R4: default area, 8-bit and 3 waits, enable bit ignored; stray field write
    cfgWrite(4, 2, 8'h0D);
    cfgWrite(4, 0, 8'hFF);
    doAccess(24'h500000, 1'b0);
    // R9: start pulse during a busy access
    doAccess(24'h9ABCDE, 1'b1);
    doAccess(24'h500000, 1'b1);

    for (int i = 0; i < 150; i++) begin
      logic [23:0] a;
      cfgWrite($urandom % 5, $urandom % 4, 8'($urandom));
      if ($urandom % 2)
        a = {bStart[$urandom % 4], 16'($urandom)};
      else
        a = 24'($urandom);
      doAccess(a, ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule